// File: doc/BRIEF.md
# Light Threshold Window Interrupt with Persistence Filter

This block watches a stream of 16-bit light readings and decides when the light has left a programmable window. Each accepted reading is compared against an upper bound and a lower bound. A reading above the upper bound, or below the lower bound, counts as a crossing in that direction. A crossing only becomes an event after a programmable run of consecutive crossings in the same direction. The run length is 1, 2, 4 or 8 readings.

An event latches a per-direction flag in a status word. While interrupts are enabled, the event also pulls the active-low open-drain interrupt line low. Software reads the status word, and the read strobe clears both flags and releases the line. The bus that carries the register writes and reads sits outside this block, and so does the converter that produces the readings. The threshold registers are presented to the block as full 16-bit values.

Top module: `lux_window_irq`

## Requirements
- R1: After reset both flags are 0, the status word reads 0x0000, `irq_n` is 1 (released) and the run counter is empty.
- R2: A reading counts as an upper crossing only when it is strictly greater than `thr_upper`, and as a lower crossing only when it is strictly less than `thr_lower`. A reading equal to either bound is inside the window.
- R3: If a reading satisfies both conditions (bounds programmed inverted), it counts as an upper crossing only.
- R4: `pers_sel` selects the run length: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 8 consecutive crossings. The flag appears after the clock edge that accepts the reading which completes the run.
- R5: An in-window reading empties the run counter. A crossing in the opposite direction restarts the run at 1 in the new direction.
- R6: Status word layout: bit 15 = lower-bound flag, bit 14 = upper-bound flag, bits 13..0 always 0.
- R7: `irq_n` is 0 exactly when `irq_en` is 1 and at least one flag is set; otherwise it is 1, which means released.
- R8: While `irq_en` is 0, the run counter is held empty and no flag can be set. Readings have no effect.
- R9: `stat_rd` clears both flags at the next clock edge. A qualifying event accepted at the same edge still sets its flag.
- R10: Flags stay latched through later readings, including in-window ones. Once a run is complete, each further consecutive crossing in that direction qualifies again.
- R11: A cycle with `smp_vld` = 0 neither advances nor empties the run counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | New reading present this cycle |
| smp_data | input | 16 | Light reading |
| thr_upper | input | 16 | Upper window bound |
| thr_lower | input | 16 | Lower window bound |
| pers_sel | input | 2 | Run length code |
| irq_en | input | 1 | Interrupt function enable |
| stat_rd | input | 1 | Status word read strobe |
| stat_word | output | 16 | Flags in bits 15 (lower) and 14 (upper) |
| irq_n | output | 1 | Open-drain interrupt, 0 = drive low, 1 = released |

## Verification
A wrong run count or a wrong direction state shows up at the ports as a flag that appears one or more readings early or late. It can also show up as a flag in the wrong bit of the status word, so each run-length code is driven to exactly one reading short of and exactly at its run length. Interruptions of a run are covered too: an in-window reading, an opposite crossing, a gap without `smp_vld`, and dropping `irq_en`. A corrupted counter is then visible on the very next reading that ought, or ought not, to complete a run. Flag latching and clearing are visible one edge after a read, and the race between a read and a new event is driven directly.

// File: rtl/lwi_pkg.sv
package lwi_pkg;
   typedef enum logic [1:0] {
      DIR_NONE  = 2'd0,
      DIR_UPPER = 2'd1,
      DIR_LOWER = 2'd2
   } cross_dir_e;
endpackage

// File: rtl/lwi_classify.sv
module lwi_classify #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] smp_data,
   input  logic [DATA_W-1:0] thr_upper,
   input  logic [DATA_W-1:0] thr_lower,
   output logic              above,
   output logic              below
);
   if (DATA_W < 2) begin : g_bad_width
      $error("lwi_classify: DATA_W must be at least 2");
   end

   // upper crossing has priority when bounds are inverted
   always_comb begin
      above = (smp_data > thr_upper);
      below = !above && (smp_data < thr_lower);
   end
endmodule

// File: rtl/lwi_persist.sv
module lwi_persist
   import lwi_pkg::*;
#(
   parameter int PERS_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              vld,
   input  logic              above,
   input  logic              below,
   input  logic [PERS_W-1:0] pers_sel,
   output logic              hit_upper,
   output logic              hit_lower
);
   localparam int MAX_TGT = 1 << ((1 << PERS_W) - 1);
   localparam int CNT_W   = $clog2(MAX_TGT) + 1;

   if (PERS_W < 1 || PERS_W > 3) begin : g_bad_pers
      $error("lwi_persist: PERS_W must be 1..3");
   end

   cross_dir_e       dir_q, dir_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, target;

   always_comb begin
      target = CNT_W'(1) << pers_sel;
      dir_d  = dir_q;
      cnt_d  = cnt_q;
      if (!en) begin
         dir_d = DIR_NONE;
         cnt_d = '0;
      end else if (vld) begin
         if (above || below) begin
            dir_d = above ? DIR_UPPER : DIR_LOWER;
            if (dir_q == dir_d)
               cnt_d = (cnt_q >= target) ? target : cnt_q + CNT_W'(1);
            else
               cnt_d = CNT_W'(1);
         end else begin
            dir_d = DIR_NONE;
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_NONE;
         cnt_q <= '0;
      end else begin
         dir_q <= dir_d;
         cnt_q <= cnt_d;
      end
   end

   always_comb begin
      hit_upper = en && vld && above && (cnt_d == target);
      hit_lower = en && vld && below && (cnt_d == target);
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_TGT)); // R4
   AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == '0); // R8
   AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      en && !vld |=> $stable(cnt_q)); // R11
   AST_WINDOW_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      en && vld && !above && !below |=> cnt_q == '0); // R5
endmodule

// File: rtl/lwi_flags.sv
module lwi_flags #(
   parameter int DATA_W  = 16,
   parameter int LO_BIT  = 15,
   parameter int HI_BIT  = 14,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              hit_upper,
   input  logic              hit_lower,
   input  logic              rd,
   output logic [DATA_W-1:0] status,
   output logic              irq_n
);
   if (LO_BIT >= DATA_W || HI_BIT >= DATA_W || LO_BIT == HI_BIT) begin : g_bad_bits
      $error("lwi_flags: flag bit positions invalid");
   end

   logic flag_lo, flag_hi, irq_act;

   // read clears first, a same-edge event sets afterwards
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_lo <= 1'b0;
         flag_hi <= 1'b0;
      end else begin
         flag_lo <= hit_lower | (flag_lo & ~rd);
         flag_hi <= hit_upper | (flag_hi & ~rd);
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_stat
      if (b == LO_BIT) begin : g_lo
         assign status[b] = flag_lo;
      end else if (b == HI_BIT) begin : g_hi
         assign status[b] = flag_hi;
      end else begin : g_zero
         assign status[b] = 1'b0;
      end
   end

   assign irq_act = en & (flag_lo | flag_hi);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~irq_act;
      end
   end else begin : g_irq_comb
      assign irq_n = ~irq_act;
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !en |-> irq_n); // R7
   end

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !hit_upper && !hit_lower |=> status == '0); // R9
   AST_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_lo && !rd |=> flag_lo); // R10
   AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_hi && !rd |=> flag_hi); // R10
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq #(
   parameter int DATA_W  = 16,
   parameter int PERS_W  = 2,
   parameter int LO_BIT  = 15,
   parameter int HI_BIT  = 14,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [DATA_W-1:0] thr_upper,
   input  logic [DATA_W-1:0] thr_lower,
   input  logic [PERS_W-1:0] pers_sel,
   input  logic              irq_en,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] stat_word,
   output logic              irq_n
);
   logic above, below, hit_upper, hit_lower;

   lwi_classify #(.DATA_W(DATA_W)) u_cls (
      .smp_data (smp_data),
      .thr_upper(thr_upper),
      .thr_lower(thr_lower),
      .above    (above),
      .below    (below)
   );

   lwi_persist #(.PERS_W(PERS_W)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (irq_en),
      .vld      (smp_vld),
      .above    (above),
      .below    (below),
      .pers_sel (pers_sel),
      .hit_upper(hit_upper),
      .hit_lower(hit_lower)
   );

   lwi_flags #(.DATA_W(DATA_W), .LO_BIT(LO_BIT), .HI_BIT(HI_BIT), .IRQ_REG(IRQ_REG)) u_flg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (irq_en),
      .hit_upper(hit_upper),
      .hit_lower(hit_lower),
      .rd       (stat_rd),
      .status   (stat_word),
      .irq_n    (irq_n)
   );

   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_upper, hit_lower})); // R3
   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !$rose(stat_word[LO_BIT]) && !$rose(stat_word[HI_BIT])); // R8
endmodule

// File: tb/lux_window_irq_tb_top.sv
`timescale 1ns/1ps
module lux_window_irq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [15:0] smp_data = '0;
   logic [15:0] thr_upper = 16'd1000;
   logic [15:0] thr_lower = 16'd100;
   logic [1:0]  pers_sel = 2'd0;
   logic        irq_en = 1'b0;
   logic        stat_rd = 1'b0;
   logic [15:0] stat_word;
   logic        irq_n;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lux_window_irq dut_i (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .thr_upper(thr_upper), .thr_lower(thr_lower), .pers_sel(pers_sel),
      .irq_en(irq_en), .stat_rd(stat_rd), .stat_word(stat_word), .irq_n(irq_n)
   );

   typedef struct packed {
      logic        en;
      logic        vld;
      logic        rd;
      logic [1:0]  pers;
      logic [15:0] data;
      logic [15:0] exp_stat;
      logic        exp_irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 43;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1,1'b1,1'b0,2'd0,16'd500 ,16'h0000,1'b1,4'd2 }, // R2 inside
      '{1'b1,1'b1,1'b0,2'd0,16'd1000,16'h0000,1'b1,4'd2 }, // R2 equal upper
      '{1'b1,1'b1,1'b0,2'd0,16'd1001,16'h4000,1'b0,4'd4 }, // R4 run 1, R6 bit 14
      '{1'b1,1'b0,1'b1,2'd0,16'd0   ,16'h0000,1'b1,4'd9 }, // R9 read clears
      '{1'b1,1'b1,1'b0,2'd0,16'd100 ,16'h0000,1'b1,4'd2 }, // R2 equal lower
      '{1'b1,1'b1,1'b0,2'd0,16'd99  ,16'h8000,1'b0,4'd6 }, // R6 bit 15
      '{1'b1,1'b1,1'b0,2'd0,16'd500 ,16'h8000,1'b0,4'd10}, // R10 latched
      '{1'b1,1'b0,1'b1,2'd0,16'd0   ,16'h0000,1'b1,4'd9 }, // R9
      '{1'b1,1'b1,1'b0,2'd1,16'd2000,16'h0000,1'b1,4'd4 }, // R4 1 of 2
      '{1'b1,1'b1,1'b0,2'd1,16'd50  ,16'h0000,1'b1,4'd5 }, // R5 opposite restarts
      '{1'b1,1'b1,1'b0,2'd1,16'd50  ,16'h8000,1'b0,4'd4 }, // R4 2 of 2
      '{1'b1,1'b0,1'b1,2'd1,16'd0   ,16'h0000,1'b1,4'd9 }, // R9
      '{1'b1,1'b1,1'b0,2'd2,16'd2000,16'h0000,1'b1,4'd4 }, // R4 run 4
      '{1'b1,1'b1,1'b0,2'd2,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd2,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b0,1'b0,2'd2,16'd2000,16'h0000,1'b1,4'd11}, // R11 gap
      '{1'b1,1'b1,1'b0,2'd2,16'd2000,16'h4000,1'b0,4'd11}, // R11 4th counts
      '{1'b1,1'b1,1'b1,2'd2,16'd2000,16'h4000,1'b0,4'd9 }, // R9 event wins read
      '{1'b1,1'b0,1'b1,2'd2,16'd0   ,16'h0000,1'b1,4'd9 },
      '{1'b1,1'b1,1'b0,2'd2,16'd2000,16'h4000,1'b0,4'd10}, // R10 re-qualify
      '{1'b1,1'b0,1'b1,2'd2,16'd0   ,16'h0000,1'b1,4'd9 },
      '{1'b1,1'b1,1'b0,2'd2,16'd500 ,16'h0000,1'b1,4'd5 }, // R5 empties
      '{1'b1,1'b1,1'b0,2'd2,16'd2000,16'h0000,1'b1,4'd5 }, // R5 only 1 of 4
      '{1'b1,1'b1,1'b0,2'd3,16'd500 ,16'h0000,1'b1,4'd5 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 }, // R4 run 8
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h0000,1'b1,4'd4 },
      '{1'b1,1'b1,1'b0,2'd3,16'd2000,16'h4000,1'b0,4'd4 },
      '{1'b1,1'b0,1'b1,2'd3,16'd0   ,16'h0000,1'b1,4'd9 },
      '{1'b0,1'b1,1'b0,2'd0,16'd5000,16'h0000,1'b1,4'd8 }, // R8 ignored
      '{1'b0,1'b1,1'b0,2'd0,16'd5000,16'h0000,1'b1,4'd8 },
      '{1'b1,1'b1,1'b0,2'd0,16'd500 ,16'h0000,1'b1,4'd8 },
      '{1'b1,1'b1,1'b0,2'd1,16'd2000,16'h0000,1'b1,4'd8 }, // 1 of 2
      '{1'b0,1'b0,1'b0,2'd1,16'd0   ,16'h0000,1'b1,4'd8 }, // R8 disable empties
      '{1'b1,1'b1,1'b0,2'd1,16'd2000,16'h0000,1'b1,4'd8 }, // restarts at 1
      '{1'b1,1'b1,1'b0,2'd1,16'd2000,16'h4000,1'b0,4'd4 },
      '{1'b0,1'b0,1'b0,2'd1,16'd0   ,16'h4000,1'b1,4'd7 }, // R7 gated release
      '{1'b1,1'b0,1'b0,2'd1,16'd0   ,16'h4000,1'b0,4'd7 }, // R7 drives again
      '{1'b1,1'b0,1'b1,2'd1,16'd0   ,16'h0000,1'b1,4'd9 }
   };

   task automatic check(input string tag, input logic [15:0] exp_stat, input logic exp_irq);
      n_chk++;
      if (stat_word !== exp_stat || irq_n !== exp_irq) begin
         n_fail++;
         $display("FAIL %s: stat=%h irq_n=%b expected stat=%h irq_n=%b",
                  tag, stat_word, irq_n, exp_stat, exp_irq);
      end
   endtask

   task automatic step(input logic en, input logic vld, input logic rd,
                       input logic [1:0] pers, input logic [15:0] data);
      irq_en = en; smp_vld = vld; stat_rd = rd; pers_sel = pers; smp_data = data;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 16'h0000, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         step(VEC[i].en, VEC[i].vld, VEC[i].rd, VEC[i].pers, VEC[i].data);
         check($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].exp_stat, VEC[i].exp_irq);
      end
      // R3: inverted bounds, reading above upper and below lower
      thr_upper = 16'd1000; thr_lower = 16'd2000;
      step(1'b1, 1'b1, 1'b0, 2'd0, 16'd1500);
      check("R3 upper priority", 16'h4000, 1'b0);
      step(1'b1, 1'b1, 1'b0, 2'd0, 16'd500);
      check("R3 lower alone", 16'hC000, 1'b0);
      // R1: reset with flags set, counter emptied
      thr_upper = 16'd1000; thr_lower = 16'd100;
      step(1'b1, 1'b1, 1'b0, 2'd1, 16'd2000);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears flags", 16'h0000, 1'b1);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b0, 2'd1, 16'd2000);
      check("R1 counter empty after reset", 16'h0000, 1'b1);
      step(1'b1, 1'b1, 1'b0, 2'd1, 16'd2000);
      check("R1 run completes", 16'h4000, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule